// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block guesses whether a conditional branch will be taken, for use in the fetch stage of a pipelined core. It keeps one shift register with the directions of the most recent resolved branches and a table of two-bit saturating counters. To look up a branch, the word-address bits of its PC are XORed with the history to pick one counter. The counter's upper bit is the prediction. Because the PC takes part in the hash, two branches that see the same recent history usually land on different counters.

The lookup port is purely combinational: a PC goes in and a taken/not-taken guess comes out in the same cycle. When a branch resolves, the execute stage presents its PC and its real direction with a valid strobe. In that single clock edge the selected counter moves one step toward the outcome, and the outcome is shifted into the history. The counter is selected with the history as it stood before the shift.

Top module: `gxp_predictor`

## Requirements
- R1: A synchronous active-high reset clears the history to all zeros and sets every counter to weakly taken (2'b10), so every lookup in the cycle after reset predicts taken.
- R2: The lookup output equals bit 1 of the counter at index PC[IDX_W+1:2] XOR history (the history's low IDX_W bits, or the history zero-extended if it is shorter). Codes 2'b11 and 2'b10 give taken (1), and codes 2'b01 and 2'b00 give not taken (0).
- R3: A valid update with outcome taken (up_taken=1) increments the selected counter, which stays at 2'b11 once it gets there.
- R4: A valid update with outcome not taken (up_taken=0) decrements the selected counter, which stays at 2'b00 once it gets there.
- R5: Each valid update shifts its outcome into history bit 0 and moves older bits up by one place, dropping the oldest.
- R6: The counter written by an update is selected with the history from before that update's shift. The counter write and the history shift happen at the same clock edge.
- R7: While up_valid is low, neither the history nor any counter changes, whatever up_pc and up_taken carry.
- R8: PC bits 1:0 and PC bits above IDX_W+1 affect neither lookup nor update index selection.
- R9: A counter in a strong state changes its prediction only after two consecutive opposite outcomes at that index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | PC of the branch being fetched |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Strobe: a branch has resolved this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual direction of the resolved branch |

## Verification
A wrong history bit moves the XOR index. On the very next lookup, the predictions for the whole PC range come out as a permuted version of the expected counter map. A counter that steps wrongly, wraps instead of saturating, or is written at the post-shift index shows up only when that counter is next probed. The bench therefore steers updates onto a fixed index and probes that index right after each step. It also sweeps every index after each update, so any divergence is visible within one update.

// File: rtl/gxp_pkg.sv
package gxp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_t;

    localparam ctr_t CTR_INIT = CTR_WT;

    typedef struct packed {
        logic valid;
        logic taken;
    } upd_ctl_t;

    function automatic ctr_t ctr_step(ctr_t cur, logic taken);
        ctr_t nxt;
        case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            default: nxt = taken ? CTR_ST  : CTR_WT;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/gxp_hist.sv
module gxp_hist #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);
    always_ff @(posedge clk) begin
        if (rst)
            hist <= '0;
        else if (shift_en)
            hist <= {hist[HIST_W-2:0], shift_bit};
    end
endmodule

// File: rtl/gxp_hash.sv
module gxp_hash #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 10,
    parameter int IDX_W  = 10
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    localparam int PC_LO = 2;
    localparam int PC_HI = IDX_W + PC_LO - 1;

    logic [IDX_W-1:0] hist_fit;
    logic             unused_pc_bits;

    generate
        if (HIST_W >= IDX_W) begin : g_trunc
            logic unused_hist_bits;
            assign hist_fit = hist[IDX_W-1:0];
            if (HIST_W > IDX_W) begin : g_extra
                assign unused_hist_bits = ^hist[HIST_W-1:IDX_W];
            end else begin : g_none
                assign unused_hist_bits = 1'b0;
            end
        end else begin : g_zext
            assign hist_fit = {{(IDX_W-HIST_W){1'b0}}, hist};
        end
    endgenerate

    assign unused_pc_bits = ^{pc[PC_W-1:PC_HI+1], pc[PC_LO-1:0]};
    assign idx = pc[PC_HI:PC_LO] ^ hist_fit;
endmodule

// File: rtl/gxp_ctr_table.sv
module gxp_ctr_table
    import gxp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t tbl [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                tbl[i] <= CTR_INIT;
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
        end
    end

    assign rd_ctr = tbl[rd_idx];
endmodule

// File: rtl/gxp_predictor.sv
module gxp_predictor
    import gxp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int HIST_W = 10,
    parameter int IDX_W  = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    logic [HIST_W-1:0] hist_q;
    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  up_idx;
    ctr_t              lk_ctr;
    upd_ctl_t          upd;

    assign upd = '{valid: up_valid, taken: up_taken};

    gxp_hist #(.HIST_W(HIST_W)) hist_i (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (upd.valid),
        .shift_bit (upd.taken),
        .hist      (hist_q)
    );

    gxp_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) lk_hash_i (
        .pc   (lk_pc),
        .hist (hist_q),
        .idx  (lk_idx)
    );

    gxp_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) up_hash_i (
        .pc   (up_pc),
        .hist (hist_q),
        .idx  (up_idx)
    );

    gxp_ctr_table #(.IDX_W(IDX_W)) tbl_i (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_idx),
        .rd_ctr   (lk_ctr),
        .wr_en    (upd.valid),
        .wr_idx   (up_idx),
        .wr_taken (upd.taken)
    );

    assign lk_taken = ctr_says_taken(lk_ctr);
endmodule

// File: rtl/gxp_predictor_chk.sv
module gxp_predictor_chk #(
    parameter int HIST_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              up_valid,
    input logic              up_taken,
    input logic              lk_taken,
    input logic [HIST_W-1:0] hist_q
);
    // R1
    reset_hist_chk: assert property (@(posedge clk) rst |=> (hist_q == '0));

    // R1
    reset_pred_chk: assert property (@(posedge clk) rst |=> lk_taken);

    // R5
    hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !rst) |=> (hist_q == {$past(hist_q[HIST_W-2:0]), $past(up_taken)}));

    // R7
    hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!up_valid && !rst) |=> $stable(hist_q));
endmodule

bind gxp_predictor gxp_predictor_chk #(.HIST_W(HIST_W)) chk_i (.*);

// File: tb/gxp_predictor_tb_top.sv
`timescale 1ns/1ps
module gxp_predictor_tb_top;
    localparam int PC_W  = 16;
    localparam int HW    = 4;
    localparam int IW    = 4;
    localparam int DEPTH = 1 << IW;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_taken;
    logic            up_valid = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic            up_taken = 1'b0;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [1:0]    m_ctr [DEPTH];
    logic [HW-1:0] m_hist;

    always #2 clk = ~clk;

    gxp_predictor #(.PC_W(PC_W), .HIST_W(HW), .IDX_W(IW)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .lk_pc    (lk_pc),
        .lk_taken (lk_taken),
        .up_valid (up_valid),
        .up_pc    (up_pc),
        .up_taken (up_taken)
    );

    task automatic check(input string req, input logic got, input logic exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: lk_pc=%h got %b expected %b", req, lk_pc, got, exp);
        end
    endtask

    task automatic model_reset();
        m_hist = '0;
        for (int i = 0; i < DEPTH; i++) m_ctr[i] = 2'b10;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        up_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic do_update(input logic [PC_W-1:0] pc, input logic t);
        logic [IW-1:0] ix;
        @(negedge clk);
        up_pc = pc;
        up_taken = t;
        up_valid = 1'b1;
        @(negedge clk);
        up_valid = 1'b0;
        ix = pc[IW+1:2] ^ m_hist;
        if (t && m_ctr[ix] != 2'b11) m_ctr[ix] = m_ctr[ix] + 2'd1;
        if (!t && m_ctr[ix] != 2'b00) m_ctr[ix] = m_ctr[ix] - 2'd1;
        m_hist = {m_hist[HW-2:0], t};
    endtask

    task automatic upd_idx(input logic [IW-1:0] ix, input logic t);
        logic [IW-1:0] raw;
        raw = ix ^ m_hist;
        do_update({{(PC_W-IW-2){1'b0}}, raw, 2'b00}, t);
    endtask

    task automatic probe_idx(input string req, input logic [IW-1:0] ix, input logic exp);
        logic [IW-1:0] raw;
        raw = ix ^ m_hist;
        lk_pc = {{(PC_W-IW-2){1'b0}}, raw, 2'b00};
        #1;
        check(req, lk_taken, exp);
    endtask

    task automatic sweep(input string req, input logic [PC_W-1:0] junk);
        for (int i = 0; i < DEPTH; i++) begin
            logic [IW-1:0] raw;
            raw = i[IW-1:0];
            lk_pc = {junk[PC_W-1:IW+2], raw, junk[1:0]};
            #1;
            check(req, lk_taken, m_ctr[raw ^ m_hist][1]);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        model_reset();
        do_reset();
        // R1: every index predicts taken after reset
        sweep("R1", '0);

        // R3 / R4 / R9 on a fixed index, steering PC around the history
        upd_idx(4'd5, 1'b1);
        upd_idx(4'd5, 1'b1);
        upd_idx(4'd5, 1'b1);
        upd_idx(4'd5, 1'b0);
        probe_idx("R3", 4'd5, 1'b1);
        upd_idx(4'd5, 1'b0);
        probe_idx("R9", 4'd5, 1'b0);
        upd_idx(4'd5, 1'b0);
        upd_idx(4'd5, 1'b0);
        upd_idx(4'd5, 1'b0);
        upd_idx(4'd5, 1'b1);
        probe_idx("R4", 4'd5, 1'b0);
        upd_idx(4'd5, 1'b1);
        probe_idx("R9", 4'd5, 1'b1);
        sweep("R2", '0);

        // R6: index taken from the history before the shift
        do_reset();
        do_update(16'h0000, 1'b1);
        do_update(16'h0018, 1'b0);
        probe_idx("R6", 4'd7, 1'b0);
        probe_idx("R6", 4'd4, 1'b1);
        probe_idx("R6", 4'd0, 1'b1);

        // R8: junk in PC low and high bits
        sweep("R8", 16'hA5C3);
        do_update(16'hF003 | {10'd0, (4'd9 ^ m_hist), 2'b00}, 1'b0);
        do_update(16'h7002 | {10'd0, (4'd9 ^ m_hist), 2'b00}, 1'b0);
        probe_idx("R8", 4'd9, 1'b0);
        sweep("R8", 16'h5FFF);

        // R7: no strobe, busy update inputs
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            up_pc = 16'h1234 + 16'(k * 52);
            up_taken = k[0];
        end
        @(negedge clk);
        sweep("R7", '0);

        // R5: pseudo-random outcome stream
        lfsr = 8'hB7;
        for (int n = 0; n < 60; n++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            do_update({8'h00, lfsr}, lfsr[6]);
            sweep("R5", '0);
        end

        // R1: reset again mid-run
        do_reset();
        sweep("R1", 16'hFFFF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule